// File: doc/BRIEF.md
# Toggle-Pump Fill Tracker with Burst Trigger

This block sits between a pixel capture path running on a slow pixel clock and a memory-write engine running on a faster bus clock. On the pixel side it packs four 10-bit lanes into one 64-bit buffer entry, with each pixel zero-extended to a 16-bit slot. It writes that entry to an external buffer memory only on cycles where the control lane marks the pixel data as valid. A running write count numbers the entries.

The block never carries the write count across the clock boundary as a multi-bit value. Only the count's least significant bit crosses. That bit flips once per stored entry and passes through a three-stage flip-flop chain into the bus domain. There, every edge seen between the last two stages bumps a bus-side copy of the write count. The buffer level is that copy minus the read pointer.

When the level reaches both a programmable threshold and the size of one transaction, the block raises a request. A transaction is a fixed number of bursts, each of a fixed number of beats. The request stays high until the memory engine answers with a one-cycle done pulse. The done pulse advances the read pointer by one transaction's worth of entries. The scheme relies on the bus clock being several times faster than the pixel clock, so that no toggle of the crossing bit is missed.

Top module: `pump_fill_trigger`

## Requirements
- R1: The buffer write strobe rises for exactly one pixel-clock cycle, in the cycle after each pixel-clock cycle in which the valid flag was high, and at no other time.
- R2: Each written entry places lane i in bits [16i+9:16i] and zeros in bits [16i+15:16i+10]. Its address equals the number of earlier writes since reset, modulo 2^CNT_W. Consecutive writes use consecutive addresses.
- R3: The fill level never exceeds the true number of stored-but-unconsumed entries, never goes negative (its MSB stays clear in normal use), and rises by at most one per bus-clock cycle.
- R4: After writes stop, the fill level equals the true occupancy within four bus-clock cycles.
- R5: The request rises in the bus cycle after the block is idle with a level at least equal to both the threshold and the transaction size. It then stays high until done is sampled high.
- R6: A done pulse while the request is high advances the read pointer by the transaction size and drops the request on the next edge. At all other times the read pointer holds.
- R7: One transaction covers BURSTS × BEATS × BEAT_BYTES bytes, which is that byte count divided by 8 buffer entries (512 entries at the default 16 × 16 × 16).
- R8: After reset the write strobe, request, fill level and read pointer are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Pixel clock |
| wr_rst | input | 1 | Synchronous active-high reset, pixel domain |
| pix_valid | input | 1 | Control lane marks this cycle's pixels valid |
| lane_px | input | LANES*PIX_W | Four adjacent lane pixels, lane 0 in the low bits |
| buf_we | output | 1 | Buffer write strobe |
| buf_waddr | output | CNT_W | Buffer write address |
| buf_wdata | output | LANES*SLOT_W | Packed buffer entry |
| rd_clk | input | 1 | Bus clock |
| rd_rst | input | 1 | Synchronous active-high reset, bus domain |
| threshold | input | CNT_W | Level at which a transaction may start |
| xfer_done | input | 1 | One-cycle completion pulse from the write engine |
| xfer_req | output | 1 | Transaction request |
| rd_ptr | output | CNT_W | Entries consumed so far |
| fill_level | output | CNT_W | Bus-side buffer level |

## Verification
The bench builds the block with CNT_W=8, 2 bursts of 4 beats of 16 bytes, so one transaction is 16 entries. The small transaction lets many request/done cycles happen in a short run. The 8-bit counters wrap many times, which exercises modular level arithmetic across the wrap. The pixel clock runs at 50 MHz and the bus clock at 250 MHz, with a random valid pattern. Threshold runs cover values above, equal to and below the transaction size, so both parts of the trigger condition get their turn at being the deciding limit.

// File: rtl/pump_fill_pkg.sv
package pump_fill_pkg;
  function automatic int entries_per_xfer(int bursts, int beats, int beat_bytes, int entry_bits);
    return (bursts * beats * beat_bytes) / (entry_bits / 8);
  endfunction
endpackage

// File: rtl/pump_wr_side.sv
module pump_wr_side #(
  parameter int LANES  = 4,
  parameter int PIX_W  = 10,
  parameter int SLOT_W = 16,
  parameter int CNT_W  = 12
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      pix_valid,
  input  logic [LANES*PIX_W-1:0]    lane_px,
  output logic                      buf_we,
  output logic [CNT_W-1:0]          buf_waddr,
  output logic [LANES*SLOT_W-1:0]   buf_wdata,
  output logic                      wr_toggle
);
  localparam int PAD_W = SLOT_W - PIX_W;

  logic [CNT_W-1:0]        wr_cnt;
  logic [LANES*SLOT_W-1:0] packed_w;

  for (genvar g = 0; g < LANES; g++) begin : g_pack
    assign packed_w[g*SLOT_W +: SLOT_W] = {{PAD_W{1'b0}}, lane_px[g*PIX_W +: PIX_W]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_cnt    <= '0;
      buf_we    <= 1'b0;
      buf_waddr <= '0;
      buf_wdata <= '0;
    end else begin
      buf_we <= pix_valid;
      if (pix_valid) begin
        buf_waddr <= wr_cnt;
        buf_wdata <= packed_w;
        wr_cnt    <= wr_cnt + 1'b1;
      end
    end
  end

  assign wr_toggle = wr_cnt[0];
endmodule

// File: rtl/pump_sync.sv
module pump_sync #(
  parameter int SYNC_LEN = 3,
  parameter int CNT_W    = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             toggle_in,
  output logic [CNT_W-1:0] shadow_cnt
);
  logic [SYNC_LEN-1:0] chain;
  logic                step;

  assign step = chain[SYNC_LEN-1] ^ chain[SYNC_LEN-2];

  always_ff @(posedge clk) begin
    if (rst) begin
      chain      <= '0;
      shadow_cnt <= '0;
    end else begin
      chain <= {chain[SYNC_LEN-2:0], toggle_in};
      if (step) shadow_cnt <= shadow_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/burst_trigger.sv
module burst_trigger #(
  parameter int CNT_W = 12,
  parameter int XFER  = 512
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] shadow_cnt,
  input  logic [CNT_W-1:0] threshold,
  input  logic             xfer_done,
  output logic             xfer_req,
  output logic [CNT_W-1:0] rd_ptr,
  output logic [CNT_W-1:0] fill_level
);
  localparam logic [CNT_W-1:0] XFER_C = CNT_W'(XFER);

  logic ready;

  assign fill_level = shadow_cnt - rd_ptr;
  assign ready      = (fill_level >= threshold) && (fill_level >= XFER_C);

  always_ff @(posedge clk) begin
    if (rst) begin
      xfer_req <= 1'b0;
      rd_ptr   <= '0;
    end else if (xfer_req) begin
      if (xfer_done) begin
        xfer_req <= 1'b0;
        rd_ptr   <= rd_ptr + XFER_C;
      end
    end else if (ready) begin
      xfer_req <= 1'b1;
    end
  end
endmodule

// File: rtl/pump_fill_trigger.sv
module pump_fill_trigger #(
  parameter int LANES      = 4,
  parameter int PIX_W      = 10,
  parameter int SLOT_W     = 16,
  parameter int CNT_W      = 12,
  parameter int SYNC_LEN   = 3,
  parameter int BURSTS     = 16,
  parameter int BEATS      = 16,
  parameter int BEAT_BYTES = 16
) (
  input  logic                    wr_clk,
  input  logic                    wr_rst,
  input  logic                    pix_valid,
  input  logic [LANES*PIX_W-1:0]  lane_px,
  output logic                    buf_we,
  output logic [CNT_W-1:0]        buf_waddr,
  output logic [LANES*SLOT_W-1:0] buf_wdata,
  input  logic                    rd_clk,
  input  logic                    rd_rst,
  input  logic [CNT_W-1:0]        threshold,
  input  logic                    xfer_done,
  output logic                    xfer_req,
  output logic [CNT_W-1:0]        rd_ptr,
  output logic [CNT_W-1:0]        fill_level
);
  localparam int ENTRY_W = LANES * SLOT_W;
  localparam int XFER_ENTRIES =
    pump_fill_pkg::entries_per_xfer(BURSTS, BEATS, BEAT_BYTES, ENTRY_W);

  logic             wr_toggle;
  logic [CNT_W-1:0] shadow_cnt;

  pump_wr_side #(.LANES(LANES), .PIX_W(PIX_W), .SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_wr (
    .clk(wr_clk), .rst(wr_rst), .pix_valid(pix_valid), .lane_px(lane_px),
    .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata), .wr_toggle(wr_toggle)
  );

  pump_sync #(.SYNC_LEN(SYNC_LEN), .CNT_W(CNT_W)) u_sync (
    .clk(rd_clk), .rst(rd_rst), .toggle_in(wr_toggle), .shadow_cnt(shadow_cnt)
  );

  burst_trigger #(.CNT_W(CNT_W), .XFER(XFER_ENTRIES)) u_trig (
    .clk(rd_clk), .rst(rd_rst), .shadow_cnt(shadow_cnt), .threshold(threshold),
    .xfer_done(xfer_done), .xfer_req(xfer_req), .rd_ptr(rd_ptr), .fill_level(fill_level)
  );
endmodule

// File: rtl/pump_fill_checker.sv
module pump_fill_checker #(
  parameter int CNT_W = 12,
  parameter int XFER  = 512
) (
  input logic             wr_clk,
  input logic             wr_rst,
  input logic             pix_valid,
  input logic             buf_we,
  input logic [CNT_W-1:0] buf_waddr,
  input logic             rd_clk,
  input logic             rd_rst,
  input logic [CNT_W-1:0] threshold,
  input logic             xfer_done,
  input logic             xfer_req,
  input logic [CNT_W-1:0] rd_ptr,
  input logic [CNT_W-1:0] fill_level
);
  p_addr_step_r2: assert property (@(posedge wr_clk) disable iff (wr_rst)
    (buf_we && pix_valid) |=> (buf_waddr == CNT_W'($past(buf_waddr) + 1'b1)));

  p_level_step_r3: assert property (@(posedge rd_clk) disable iff (rd_rst)
    !(xfer_req && xfer_done) |=> (CNT_W'(fill_level - $past(fill_level)) <= CNT_W'(1)));

  p_req_rise_r5: assert property (@(posedge rd_clk) disable iff (rd_rst)
    $rose(xfer_req) |-> ($past(fill_level) >= $past(threshold)) &&
                        ($past(fill_level) >= CNT_W'(XFER)));

  p_req_hold_r5: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (xfer_req && !xfer_done) |=> xfer_req);

  p_req_drop_r6: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (xfer_req && xfer_done) |=> (!xfer_req && rd_ptr == CNT_W'($past(rd_ptr) + CNT_W'(XFER))));

  p_ptr_hold_r6: assert property (@(posedge rd_clk) disable iff (rd_rst)
    !(xfer_req && xfer_done) |=> $stable(rd_ptr));
endmodule

bind pump_fill_trigger pump_fill_checker #(.CNT_W(CNT_W), .XFER(XFER_ENTRIES)) u_chk (
  .wr_clk(wr_clk), .wr_rst(wr_rst), .pix_valid(pix_valid), .buf_we(buf_we),
  .buf_waddr(buf_waddr), .rd_clk(rd_clk), .rd_rst(rd_rst), .threshold(threshold),
  .xfer_done(xfer_done), .xfer_req(xfer_req), .rd_ptr(rd_ptr), .fill_level(fill_level)
);

// File: tb/tb_pump_fill_trigger.sv
`timescale 1ns/1ps
module tb_pump_fill_trigger;
  localparam int CNT_W = 8;
  localparam int XFER  = 16;
  localparam int LW    = 40;
  localparam int DW    = 64;

  logic wr_clk = 0, rd_clk = 0, wr_rst = 1, rd_rst = 1;
  logic pix_valid = 0;
  logic [LW-1:0] lane_px = '0;
  logic buf_we;
  logic [CNT_W-1:0] buf_waddr, rd_ptr, fill_level;
  logic [DW-1:0] buf_wdata;
  logic [CNT_W-1:0] threshold = 8'd24;
  logic xfer_done = 0, xfer_req;

  always #10 wr_clk = ~wr_clk;
  always #2  rd_clk = ~rd_clk;

  pump_fill_trigger #(.CNT_W(CNT_W), .BURSTS(2), .BEATS(4), .BEAT_BYTES(16)) dut (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .pix_valid(pix_valid), .lane_px(lane_px),
    .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .threshold(threshold), .xfer_done(xfer_done),
    .xfer_req(xfer_req), .rd_ptr(rd_ptr), .fill_level(fill_level)
  );

  int checks = 0, errors = 0;
  int wr_total = 0, rd_model = 0;
  bit writing = 0, running = 0, finished = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] pack(input logic [LW-1:0] px);
    logic [DW-1:0] r = '0;
    for (int i = 0; i < 4; i++) r[i*16 +: 16] = {6'b0, px[i*10 +: 10]};
    return r;
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // pixel side: check previous cycle's write, then drive the next one
  logic             last_v = 0;
  logic [LW-1:0]    last_px = '0;
  initial begin
    forever begin
      @(negedge wr_clk);
      if (running) begin
        chk(buf_we == last_v, "R1 write strobe", buf_we, last_v);
        if (last_v) begin
          chk(buf_wdata == pack(last_px), "R2 packing", buf_wdata, pack(last_px));
          chk(buf_waddr == CNT_W'(wr_total - 1), "R2 address", buf_waddr, CNT_W'(wr_total - 1));
        end
        last_v  = writing && ($urandom % 3 != 0);
        last_px = {$urandom, $urandom};
        if (last_v) wr_total++;
        pix_valid = last_v;
        lane_px   = last_px;
      end
    end
  end

  // bus side: bound checks, trigger checks, done responder
  bit done_prev = 0, cond_prev = 0, req_prev = 0;
  int wait_cnt = 0;
  initial begin
    forever begin
      @(negedge rd_clk);
      if (running) begin
        int occ;
        if (done_prev) begin
          rd_model += XFER;
          chk(xfer_req == 0, "R6 request drops after done", xfer_req, 0);
        end
        chk(rd_ptr == CNT_W'(rd_model), "R6 read pointer", rd_ptr, CNT_W'(rd_model));
        occ = wr_total - rd_model;
        chk(int'(fill_level) <= occ, "R3 level within occupancy", fill_level, occ);
        chk(fill_level < (1 << (CNT_W-1)), "R3 level not negative", fill_level, 0);
        if (cond_prev && !req_prev && !done_prev)
          chk(xfer_req == 1, "R5 request raised", xfer_req, 1);
        if (req_prev && !done_prev)
          chk(xfer_req == 1, "R5 request held", xfer_req, 1);
        if (xfer_req && !req_prev)
          chk(fill_level >= threshold && fill_level >= XFER, "R5 R7 trigger level",
              fill_level, threshold);
        req_prev  = xfer_req;
        cond_prev = (fill_level >= threshold) && (fill_level >= XFER);
        done_prev = 0;
        xfer_done = 0;
        if (xfer_req) begin
          if (wait_cnt == 0) begin
            xfer_done = 1;
            done_prev = 1;
            wait_cnt  = $urandom % 6;
          end else wait_cnt--;
        end
      end
    end
  end

  task automatic quiet_check(input string tag);
    writing = 0;
    repeat (4) @(posedge wr_clk);
    repeat (12) @(posedge rd_clk);
    @(negedge rd_clk);
    #1;
    chk(int'(fill_level) == wr_total - rd_model, tag, fill_level, wr_total - rd_model);
  endtask

  initial begin
    #400_000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (5) @(posedge wr_clk);
    @(negedge wr_clk);
    chk(buf_we == 0, "R8 reset strobe", buf_we, 0);
    chk(xfer_req == 0, "R8 reset request", xfer_req, 0);
    chk(fill_level == 0, "R8 reset level", fill_level, 0);
    chk(rd_ptr == 0, "R8 reset pointer", rd_ptr, 0);
    wr_rst = 0; rd_rst = 0;
    @(posedge wr_clk);
    @(negedge wr_clk);
    running = 1;
    // threshold above transaction size
    threshold = 8'd24; writing = 1;
    repeat (2500) @(posedge wr_clk);
    quiet_check("R4 settle thr24");
    // threshold below transaction size: size decides
    threshold = 8'd4; writing = 1;
    repeat (2500) @(posedge wr_clk);
    quiet_check("R4 settle thr4");
    chk(fill_level < XFER, "R7 residue below transaction", fill_level, XFER);
    // threshold equal to transaction size
    threshold = 8'd16; writing = 1;
    repeat (2500) @(posedge wr_clk);
    quiet_check("R4 settle thr16");
    chk(rd_model > 0, "R6 transactions completed", rd_model, 1);
    repeat (20) @(posedge rd_clk);
    finish_run();
  end
endmodule